// File: doc/BRIEF.md
# Virtual Interrupt List-Register Bank

This block holds a small bank of 32-bit list registers, each carrying the identifier of one virtual interrupt presented to a virtual CPU interface. Software reaches the bank through coprocessor-style system-register requests. Each request carries encoding fields, a read or write flag, write data and the caller's exception level. In the same cycle the block decides whether the access completes, is undefined, or traps to the hypervisor with a syndrome code. A completed read returns the stored value. A completed write commits on the next clock edge.

The decision follows a fixed priority. First come the configuration enables. Then the register index is checked against the number of implemented entries. Last, the exception-level rules apply, including the hypervisor trap controls and the per-level system-register enables. Identifier bits above the implemented width are held at zero.

Top module: `vlr_bank`

## Requirements
- R1: A request is claimed only when coproc is 0b1111, opc1 is 0b100, CRn is 0b1100 and CRm[3:1] is 0b110. An unclaimed request, or no request, gives outcome 3'b000 and changes no register.
- R2: The register index is {CRm[0], opc2[2:0]}, with CRm[0] as the most significant bit, giving indices 0 to 15.
- R3: The first check is on the configuration. The access is undefined unless the 32-bit hypervisor feature and the controller feature are both present and at least one of EL2 or EL3 exists. This holds for every level and every index.
- R4: After R3, an index greater than or equal to NUM_LR gives undefined, whatever the exception level and trap settings.
- R5: Any claimed access from EL0 (req_el = 0) is undefined.
- R6: An access from EL1 traps with syndrome 0x03 when the hypervisor is enabled and either of two conditions holds. The first is that the hypervisor runs in 64-bit state, its 64-bit feature is present and the 64-bit trap bit is set. The second is that the hypervisor runs in 32-bit state and the 32-bit trap bit is set. Any other EL1 access is undefined.
- R7: An access from EL2 or EL3 completes only when that level's register-enable input is 1. Otherwise it is undefined.
- R8: rsp_outcome bit 0 means complete, bit 1 undefined and bit 2 trap. At most one bit is set. rsp_syndrome is zero except on trap.
- R9: A write commits on the clock edge only when its outcome is complete. A write that traps or is undefined leaves the register unchanged.
- R10: Only the low ID_BITS bits (at least 16) are stored. The upper bits ignore writes and read as zero.
- R11: Reset clears every register to zero. A completed read returns the masked stored value in the same cycle as the request. In every other case rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| req_el | input | 2 | Caller exception level, 0 to 3 |
| cfg_feat_hyp32 | input | 1 | 32-bit hypervisor feature present |
| cfg_feat_ctrl | input | 1 | Interrupt controller feature present |
| cfg_has_el2 | input | 1 | Hypervisor level exists |
| cfg_has_el3 | input | 1 | Secure-monitor level exists |
| cfg_el2_on | input | 1 | Hypervisor enabled for the current world |
| cfg_feat_hyp64 | input | 1 | 64-bit hypervisor feature present |
| cfg_hyp_64 | input | 1 | Hypervisor runs in 64-bit state |
| cfg_trap64 | input | 1 | Trap bit of the 64-bit hypervisor trap control |
| cfg_trap32 | input | 1 | Trap bit of the 32-bit hypervisor trap control |
| cfg_en_el2 | input | 1 | Register-enable for EL2 |
| cfg_en_el3 | input | 1 | Register-enable for EL3 |
| rsp_rdata | output | 32 | Read data, valid on a completed read |
| rsp_outcome | output | 3 | One-hot {trap, undefined, complete} |
| rsp_syndrome | output | 8 | Syndrome code, nonzero only on trap |

## Verification
A write request reaches the permission chain and the storage enable in the same cycle, so a refused write and a commit can collide. The bench provokes this with writes from EL0, from trapping EL1, from EL2 with its enable low, and to an out-of-range index. In each case it checks the reported outcome and then reads the target entry back to confirm the old value survived. Priority collisions are judged too: an out-of-range index from a trapping EL1 must report undefined, not trap. A disabled configuration must override an otherwise valid EL2 access.

// File: rtl/vlr_pkg.sv
// Package: shared constants and outcome type for the list-register bank.
// Assumes the encoding constants below identify the only claimed access.
package vlr_pkg;
    localparam logic [3:0] ENC_COPROC = 4'b1111;
    localparam logic [2:0] ENC_OPC1   = 3'b100;
    localparam logic [3:0] ENC_CRN    = 4'b1100;
    localparam logic [2:0] ENC_CRM_HI = 3'b110;
    localparam logic [7:0] SYN_HYP    = 8'h03;
    localparam int unsigned IDX_W     = 4;

    typedef enum logic [1:0] {
        LVL_EL0 = 2'd0,
        LVL_EL1 = 2'd1,
        LVL_EL2 = 2'd2,
        LVL_EL3 = 2'd3
    } lvl_t;

    typedef struct packed {
        logic trap;
        logic undef;
        logic done;
    } outcome_t;
endpackage

// File: rtl/vlr_decode.sv
// Module: matches the access encoding and forms the register index.
// Assumes the fields are stable while req_valid is high (pure combinational).
module vlr_decode
    import vlr_pkg::*;
(
    input  logic [3:0]       coproc,
    input  logic [2:0]       opc1,
    input  logic [3:0]       crn,
    input  logic [3:0]       crm,
    input  logic [2:0]       opc2,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Compare every fixed field and build the index from the split bits.
    always_comb begin
        hit = (coproc == ENC_COPROC) && (opc1 == ENC_OPC1) &&
              (crn == ENC_CRN) && (crm[3:1] == ENC_CRM_HI);
        idx = {crm[0], opc2};
    end
endmodule

// File: rtl/vlr_access_gate.sv
// Module: fixed-priority permission chain deciding complete, undefined or trap.
// Assumes NUM_LR is between 1 and 16; the index is already decoded.
module vlr_access_gate
    import vlr_pkg::*;
#(
    parameter int unsigned NUM_LR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       el,
    input  logic             feat_hyp32,
    input  logic             feat_ctrl,
    input  logic             has_el2,
    input  logic             has_el3,
    input  logic             el2_on,
    input  logic             feat_hyp64,
    input  logic             hyp_64,
    input  logic             trap64,
    input  logic             trap32,
    input  logic             en_el2,
    input  logic             en_el3,
    output outcome_t         outcome,
    output logic [7:0]       syndrome
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_LR);

    logic cfg_ok;
    logic idx_ok;
    logic trap_hit;

    // Precompute the configuration, range and EL1 trap conditions.
    always_comb begin
        cfg_ok   = feat_hyp32 && feat_ctrl && (has_el2 || has_el3);
        idx_ok   = {1'b0, idx} < LIMIT;
        trap_hit = el2_on && ((feat_hyp64 && hyp_64 && trap64) ||
                              (feat_hyp32 && !hyp_64 && trap32));
    end

    // Walk the priority chain for a claimed request.
    always_comb begin
        outcome  = '0;
        syndrome = 8'h00;
        if (valid && hit) begin
            if (!cfg_ok || !idx_ok) begin
                outcome.undef = 1'b1;
            end else begin
                case (lvl_t'(el))
                    LVL_EL0: outcome.undef = 1'b1;
                    LVL_EL1: begin
                        if (trap_hit) begin
                            outcome.trap = 1'b1;
                            syndrome     = SYN_HYP;
                        end else begin
                            outcome.undef = 1'b1;
                        end
                    end
                    LVL_EL2: begin
                        outcome.done  = en_el2;
                        outcome.undef = !en_el2;
                    end
                    default: begin
                        outcome.done  = en_el3;
                        outcome.undef = !en_el3;
                    end
                endcase
            end
        end
    end

    p_outcome_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(outcome));
    p_syndrome_only_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !outcome.trap |-> (syndrome == 8'h00));
    p_el0_never_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (el == 2'd0) |-> !outcome.done && !outcome.trap);
    p_unclaimed_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || !hit) |-> (outcome == '0));
endmodule

// File: rtl/vlr_store.sv
// Module: list-register storage, masked to ID_BITS, one read and one write port.
// Assumes the write enable is asserted only for a completed write.
module vlr_store
    import vlr_pkg::*;
#(
    parameter int unsigned NUM_LR  = 16,
    parameter int unsigned ID_BITS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    logic [ID_BITS-1:0] entry [NUM_LR];

    for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
        // Hold one entry; load the implemented bits on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[i] <= '0;
            end else if (we && (idx == IDX_W'(i))) begin
                entry[i] <= wdata[ID_BITS-1:0];
            end
        end

        p_hold_unwritten_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (idx == IDX_W'(i))) |=> $stable(entry[i]));
    end

    // Select the addressed entry and zero-extend it to 32 bits.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_LR; k++) begin
            if (idx == IDX_W'(k)) begin
                rdata = 32'(entry[k]);
            end
        end
    end

    if (ID_BITS < 32) begin : g_mask_chk
        p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rdata[31:ID_BITS] == '0);
    end
endmodule

// File: rtl/vlr_bank.sv
// Module: top of the virtual interrupt list-register bank.
// Decodes the request, applies the permission chain, and reads or writes storage.
// Assumes 1 <= NUM_LR <= 16 and 16 <= ID_BITS <= 32.
module vlr_bank
    import vlr_pkg::*;
#(
    parameter int unsigned NUM_LR  = 16,
    parameter int unsigned ID_BITS = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [3:0]  req_coproc,
    input  logic [2:0]  req_opc1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_opc2,
    input  logic [31:0] req_wdata,
    input  logic [1:0]  req_el,
    input  logic        cfg_feat_hyp32,
    input  logic        cfg_feat_ctrl,
    input  logic        cfg_has_el2,
    input  logic        cfg_has_el3,
    input  logic        cfg_el2_on,
    input  logic        cfg_feat_hyp64,
    input  logic        cfg_hyp_64,
    input  logic        cfg_trap64,
    input  logic        cfg_trap32,
    input  logic        cfg_en_el2,
    input  logic        cfg_en_el3,
    output logic [31:0] rsp_rdata,
    output logic [2:0]  rsp_outcome,
    output logic [7:0]  rsp_syndrome
);
    logic             hit;
    logic [IDX_W-1:0] idx;
    outcome_t         outcome;
    logic [31:0]      store_rdata;
    logic             store_we;

    vlr_decode u_decode (
        .coproc (req_coproc),
        .opc1   (req_opc1),
        .crn    (req_crn),
        .crm    (req_crm),
        .opc2   (req_opc2),
        .hit    (hit),
        .idx    (idx)
    );

    vlr_access_gate #(.NUM_LR(NUM_LR)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (req_valid),
        .hit        (hit),
        .idx        (idx),
        .el         (req_el),
        .feat_hyp32 (cfg_feat_hyp32),
        .feat_ctrl  (cfg_feat_ctrl),
        .has_el2    (cfg_has_el2),
        .has_el3    (cfg_has_el3),
        .el2_on     (cfg_el2_on),
        .feat_hyp64 (cfg_feat_hyp64),
        .hyp_64     (cfg_hyp_64),
        .trap64     (cfg_trap64),
        .trap32     (cfg_trap32),
        .en_el2     (cfg_en_el2),
        .en_el3     (cfg_en_el3),
        .outcome    (outcome),
        .syndrome   (rsp_syndrome)
    );

    // Commit only completed writes; return data only for completed reads.
    always_comb begin
        store_we    = outcome.done && req_write;
        rsp_rdata   = (outcome.done && !req_write) ? store_rdata : 32'h0;
        rsp_outcome = outcome;
    end

    vlr_store #(.NUM_LR(NUM_LR), .ID_BITS(ID_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .idx   (idx),
        .wdata (req_wdata),
        .rdata (store_rdata)
    );

    p_rdata_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_outcome[0] == 1'b0) |-> (rsp_rdata == 32'h0));
endmodule

// File: tb/vlr_bank_tb.sv
// Bench: directed scenarios, one task each, checking results at the ports.
module vlr_bank_tb;
    localparam int unsigned NLR = 12;
    localparam int unsigned IDB = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_coproc = 4'b1111;
    logic [2:0]  req_opc1 = 3'b100;
    logic [3:0]  req_crn = 4'b1100;
    logic [3:0]  req_crm = 4'b1100;
    logic [2:0]  req_opc2 = 3'b000;
    logic [31:0] req_wdata = 32'h0;
    logic [1:0]  req_el = 2'd2;
    logic cfg_feat_hyp32 = 1, cfg_feat_ctrl = 1, cfg_has_el2 = 1, cfg_has_el3 = 1;
    logic cfg_el2_on = 1, cfg_feat_hyp64 = 1, cfg_hyp_64 = 0;
    logic cfg_trap64 = 0, cfg_trap32 = 0, cfg_en_el2 = 1, cfg_en_el3 = 1;
    logic [31:0] rsp_rdata;
    logic [2:0]  rsp_outcome;
    logic [7:0]  rsp_syndrome;

    int checks = 0;
    int errors = 0;
    logic [31:0] got_data;
    logic [2:0]  got_out;
    logic [7:0]  got_syn;

    localparam logic [2:0] O_DONE = 3'b001, O_UNDEF = 3'b010, O_TRAP = 3'b100;

    always #4 clk = ~clk;

    vlr_bank #(.NUM_LR(NLR), .ID_BITS(IDB)) u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] el, input logic [3:0] idx,
                       input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_el = el;
        req_crm = {3'b110, idx[3]}; req_opc2 = idx[2:0]; req_wdata = wd;
        #1;
        got_data = rsp_rdata; got_out = rsp_outcome; got_syn = rsp_syndrome;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset();
        acc(1'b0, 2'd2, 4'd0, 0);
        chk("R11 reset outcome", 32'(got_out), 32'(O_DONE));
        chk("R11 reset data", got_data, 32'h0);
        acc(1'b0, 2'd3, 4'd11, 0);
        chk("R11 reset data top", got_data, 32'h0);
    endtask

    task automatic t_rw_mask();
        acc(1'b1, 2'd2, 4'd5, 32'h0012_3456);
        chk("R9 write done", 32'(got_out), 32'(O_DONE));
        chk("R11 write rdata zero", got_data, 32'h0);
        acc(1'b0, 2'd2, 4'd5, 0);
        chk("R11 readback", got_data, 32'h0012_3456);
        acc(1'b1, 2'd3, 4'd3, 32'hFFFF_FFFF);
        acc(1'b0, 2'd2, 4'd3, 0);
        chk("R10 upper bits zero", got_data, 32'h00FF_FFFF);
    endtask

    task automatic t_index();
        acc(1'b1, 2'd2, 4'd9, 32'h0000_0909);
        acc(1'b1, 2'd2, 4'd1, 32'h0000_0101);
        acc(1'b0, 2'd2, 4'd9, 0);
        chk("R2 crm0 msb idx9", got_data, 32'h0000_0909);
        acc(1'b0, 2'd2, 4'd1, 0);
        chk("R2 idx1", got_data, 32'h0000_0101);
        acc(1'b1, 2'd2, 4'd13, 32'h1);
        chk("R4 idx13 undef", 32'(got_out), 32'(O_UNDEF));
        acc(1'b0, 2'd2, 4'd12, 0);
        chk("R4 idx12 undef", 32'(got_out), 32'(O_UNDEF));
        acc(1'b0, 2'd2, 4'd11, 0);
        chk("R4 idx11 done", 32'(got_out), 32'(O_DONE));
        cfg_trap32 = 1;
        acc(1'b0, 2'd1, 4'd14, 0);
        chk("R4 range before trap", 32'(got_out), 32'(O_UNDEF));
        chk("R8 syndrome zero", 32'(got_syn), 32'h0);
        cfg_trap32 = 0;
    endtask

    task automatic t_levels();
        acc(1'b1, 2'd0, 4'd5, 32'h0000_AAAA);
        chk("R5 el0 undef", 32'(got_out), 32'(O_UNDEF));
        acc(1'b0, 2'd2, 4'd5, 0);
        chk("R9 el0 write dropped", got_data, 32'h0012_3456);
        acc(1'b0, 2'd1, 4'd5, 0);
        chk("R6 el1 no trap undef", 32'(got_out), 32'(O_UNDEF));
        cfg_trap32 = 1;
        acc(1'b1, 2'd1, 4'd5, 32'h0000_BBBB);
        chk("R6 trap32 outcome", 32'(got_out), 32'(O_TRAP));
        chk("R6 trap32 syndrome", 32'(got_syn), 32'h03);
        cfg_hyp_64 = 1;
        acc(1'b0, 2'd1, 4'd5, 0);
        chk("R6 trap32 ignored in 64-bit", 32'(got_out), 32'(O_UNDEF));
        cfg_trap32 = 0; cfg_trap64 = 1;
        acc(1'b0, 2'd1, 4'd5, 0);
        chk("R6 trap64 outcome", 32'(got_out), 32'(O_TRAP));
        chk("R6 trap64 syndrome", 32'(got_syn), 32'h03);
        cfg_el2_on = 0;
        acc(1'b0, 2'd1, 4'd5, 0);
        chk("R6 hyp off undef", 32'(got_out), 32'(O_UNDEF));
        cfg_el2_on = 1; cfg_trap64 = 0; cfg_hyp_64 = 0;
        acc(1'b0, 2'd2, 4'd5, 0);
        chk("R9 trapped write dropped", got_data, 32'h0012_3456);
        cfg_en_el2 = 0;
        acc(1'b1, 2'd2, 4'd5, 32'h0000_CCCC);
        chk("R7 el2 disabled undef", 32'(got_out), 32'(O_UNDEF));
        acc(1'b0, 2'd3, 4'd5, 0);
        chk("R7 el3 enabled done", 32'(got_out), 32'(O_DONE));
        chk("R9 el2 disabled write dropped", got_data, 32'h0012_3456);
        cfg_en_el2 = 1; cfg_en_el3 = 0;
        acc(1'b0, 2'd3, 4'd5, 0);
        chk("R7 el3 disabled undef", 32'(got_out), 32'(O_UNDEF));
        cfg_en_el3 = 1;
    endtask

    task automatic t_config();
        cfg_feat_ctrl = 0;
        acc(1'b1, 2'd2, 4'd5, 32'h0000_DDDD);
        chk("R3 feature off undef", 32'(got_out), 32'(O_UNDEF));
        cfg_feat_ctrl = 1; cfg_feat_hyp32 = 0; cfg_trap64 = 1; cfg_hyp_64 = 1;
        acc(1'b0, 2'd1, 4'd5, 0);
        chk("R3 before trap", 32'(got_out), 32'(O_UNDEF));
        cfg_feat_hyp32 = 1; cfg_trap64 = 0; cfg_hyp_64 = 0;
        cfg_has_el2 = 0;
        acc(1'b0, 2'd2, 4'd5, 0);
        chk("R3 el3 only done", got_data, 32'h0012_3456);
        cfg_has_el3 = 0;
        acc(1'b0, 2'd2, 4'd5, 0);
        chk("R3 no levels undef", 32'(got_out), 32'(O_UNDEF));
        cfg_has_el2 = 1; cfg_has_el3 = 1;
    endtask

    task automatic t_encoding();
        @(negedge clk);
        req_coproc = 4'b1110; req_valid = 1'b1; req_write = 1'b1;
        req_el = 2'd2; req_crm = 4'b1100; req_opc2 = 3'd5; req_wdata = 32'h0000_EEEE;
        #1; got_out = rsp_outcome;
        @(posedge clk); #1; req_valid = 1'b0; req_coproc = 4'b1111;
        chk("R1 coproc mismatch none", 32'(got_out), 32'h0);
        acc(1'b0, 2'd2, 4'd5, 0);
        chk("R1 mismatch no write", got_data, 32'h0012_3456);
        @(negedge clk);
        req_crm = 4'b0100; req_valid = 1'b1; req_write = 1'b0;
        #1; got_out = rsp_outcome;
        @(posedge clk); #1; req_valid = 1'b0;
        chk("R1 crm mismatch none", 32'(got_out), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rw_mask();
        t_index();
        t_levels();
        t_config();
        t_encoding();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule